// File: doc/BRIEF.md
# SPI Master with Encoded Chip Selects

This block is an SPI master that moves one byte per transfer to and from one of several peripherals. The block drives a group of four active-low select lines. A mode bit sets how those lines are used. In direct mode each line belongs to one peripheral, and exactly one line goes low for a transfer. In encoded mode the low three lines carry a binary peripheral number, which an external 3-to-8 active-low decoder expands into individual selects. The fourth line is then parked high, so it does not need to reach a pin. Because the all-ones code means "nobody selected", codes 0 to 6 address peripherals and code 7 is never a target.

A bank of four configuration slots sets the timing and format of a transfer. Each slot holds a clock divider, clock polarity, clock phase and a select-to-clock delay. In direct mode, slot n serves select line n. In encoded mode only two slots are used: slot 0 serves peripherals 0 to 3 and slot 1 serves peripherals 4 to 6. Software-side logic writes the slots and the mode bit through a plain write port. A transfer starts with a valid/ready request that carries the peripheral number and the byte to send. The block returns a one-cycle done pulse together with the byte it received.

Top module: `spi_csdec_master`

## Requirements
- R1: Write address 4 holds the mode bit in data bit 0 (0 = direct, 1 = encoded). After reset the block is in direct mode with every select line high, SCLK low, ready high and done low.
- R2: In direct mode, a transfer to peripheral n (0 to 3) drives cs_n[n] low and keeps the other lines high.
- R3: In encoded mode, a transfer to peripheral n (0 to 6) drives cs_n[2:0] = n and cs_n[3] = 1. The idle value on all four lines is all ones.
- R4: In encoded mode, peripherals 0 to 3 take their timing from slot 0 and peripherals 4 to 6 take it from slot 1.
- R5: In direct mode, peripheral n takes its timing from slot n.
- R6: A request that targets code 7 in encoded mode, or a peripheral number of 4 or more in direct mode, is consumed and dropped. No select line moves, SCLK does not toggle and no done pulse appears.
- R7: Write addresses 0 to 3 load slots 0 to 3. The slot fields are divider = data[7:0], polarity = data[8], phase = data[9] and delay = data[15:12]. Each SCLK half-period lasts divider+1 system clocks.
- R8: The first SCLK edge comes delay+divider+2 system clocks after the select becomes active.
- R9: The select stays active for exactly END_DLY system clocks after the last SCLK edge.
- R10: A transfer has 16 SCLK edges and moves 8 bits, MSB first, in both directions. SCLK rests at the slot's polarity. With phase 0 both sides sample on the leading edge; with phase 1 both sides sample on the trailing edge. SCLK never moves while all select lines are high.
- R11: The done pulse lasts one cycle and carries the received byte. It comes in the same cycle the select returns to idle.
- R12: Ready stays low from the acceptance of a transfer until its done pulse. A request held during that time is accepted only afterwards.
- R13: The select lines do not change while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address: 0-3 slots, 4 mode |
| reg_wdata | input | 16 | Write data |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Master idle and able to accept |
| req_dev | input | 3 | Target peripheral number |
| req_data | input | 8 | Byte to transmit |
| rsp_done | output | 1 | One-cycle transfer completion pulse |
| rsp_data | output | 8 | Byte received in the last transfer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Select lines, one-hot or encoded |

## Verification
The bench targets slot selection in encoded mode, especially peripherals 3 and 4 on either side of the group boundary. A design that indexed the slots by the raw peripheral number would show the wrong divider and delay there. It sends code 7 in encoded mode and out-of-range numbers in direct mode; a design that accepted them would pulse a select or raise done. Back-to-back requests held during a busy transfer check that the second transfer waits: a design that released ready early would change the select mid-transfer. All four polarity/phase combinations, divider 0 and divider 255 check the bit order and the exact edge timing, where an off-by-one in a counter shows up as a wrong gap.

// File: rtl/spi_csdec_pkg.sv
package spi_csdec_pkg;
    localparam int DIV_W   = 8;
    localparam int DLY_W   = 4;
    localparam int CODE_W  = 3;
    localparam int BYTE_W  = 8;
    localparam int WDATA_W = 16;
    localparam int CPOL_BIT = DIV_W;
    localparam int CPHA_BIT = DIV_W + 1;
    localparam int DLY_LSB  = 12;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             cpha;
        logic             cpol;
        logic [DIV_W-1:0] div;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } xfer_st_e;
endpackage

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
    import spi_csdec_pkg::*;
#(
    parameter int NUM_CFG = 4,
    parameter int ADDR_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WDATA_W-1:0]  wr_data,
    input  logic [CODE_W-1:0]   sel_dev,
    output logic                dec_mode_o,
    output cs_cfg_t             sel_cfg_o
);
    localparam int IDX_W = $clog2(NUM_CFG);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_CFG);

    cs_cfg_t cfg_q [NUM_CFG];
    cs_cfg_t cfg_d [NUM_CFG];
    logic    mode_q, mode_d;
    cs_cfg_t wr_cfg;
    logic [IDX_W-1:0] rd_idx;

    always_comb begin
        wr_cfg.div  = wr_data[DIV_W-1:0];
        wr_cfg.cpol = wr_data[CPOL_BIT];
        wr_cfg.cpha = wr_data[CPHA_BIT];
        wr_cfg.dly  = wr_data[DLY_LSB +: DLY_W];
        mode_d = mode_q;
        for (int i = 0; i < NUM_CFG; i++) cfg_d[i] = cfg_q[i];
        if (wr_en) begin
            if (wr_addr == MODE_ADDR) mode_d = wr_data[0];
            else if (wr_addr < MODE_ADDR) cfg_d[wr_addr[IDX_W-1:0]] = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
        end else begin
            mode_q <= mode_d;
            for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= cfg_d[i];
        end
    end

    // Encoded mode groups peripherals by the top code bit: 0-3 -> slot 0, 4-6 -> slot 1
    assign rd_idx     = mode_q ? IDX_W'(sel_dev[CODE_W-1]) : sel_dev[IDX_W-1:0];
    assign sel_cfg_o  = cfg_q[rd_idx];
    assign dec_mode_o = mode_q;
endmodule

// File: rtl/spi_cs_encoder.sv
module spi_cs_encoder
    import spi_csdec_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              dec,
    input  logic [CODE_W-1:0] dev,
    output logic [NUM_CS-1:0] cs_n_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        logic direct_sel;
        assign direct_sel = active && (dev == CODE_W'(g));
        if (g < CODE_W) begin : g_coded
            assign cs_n_o[g] = dec ? (!active || dev[g]) : !direct_sel;
        end else begin : g_spare
            assign cs_n_o[g] = dec ? 1'b1 : !direct_sel;
        end
    end

    a_r2_direct_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !dec |-> $onehot0(~cs_n_o));
endmodule

// File: rtl/spi_csdec_master.sv
module spi_csdec_master
    import spi_csdec_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int NUM_CFG = 4,
    parameter int ADDR_W  = 3,
    parameter int END_DLY = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WDATA_W-1:0]  reg_wdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [CODE_W-1:0]   req_dev,
    input  logic [BYTE_W-1:0]   req_data,
    output logic                rsp_done,
    output logic [BYTE_W-1:0]   rsp_data,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_CS-1:0]   cs_n
);
    localparam int NUM_EDGES = 2 * BYTE_W;
    localparam int EDGE_W    = $clog2(NUM_EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(NUM_EDGES - 1);
    localparam logic [DIV_W-1:0]  TAIL_CNT  = DIV_W'(END_DLY - 1);
    localparam logic [CODE_W-1:0] IDLE_CODE = '1;

    typedef struct packed {
        xfer_st_e            st;
        logic [DIV_W-1:0]    cnt;
        logic [EDGE_W-1:0]   edges;
        logic [BYTE_W-1:0]   tx;
        logic [BYTE_W-1:0]   rx;
        logic                sclk;
        logic [CODE_W-1:0]   dev;
        logic                dec;
        cs_cfg_t             cfg;
        logic                done;
        logic [BYTE_W-1:0]   rdata;
    } xfer_t;

    xfer_t   q, d;
    logic    dec_mode;
    cs_cfg_t sel_cfg;
    logic    target_ok;
    logic    leading, sample_edge;

    spi_cfg_bank #(.NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .sel_dev    (req_dev),
        .dec_mode_o (dec_mode),
        .sel_cfg_o  (sel_cfg)
    );

    spi_cs_encoder #(.NUM_CS(NUM_CS)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (q.st != ST_IDLE),
        .dec    (q.dec),
        .dev    (q.dev),
        .cs_n_o (cs_n)
    );

    assign target_ok   = dec_mode ? (req_dev != IDLE_CODE) : (int'(req_dev) < NUM_CS);
    assign leading     = !q.edges[0];
    assign sample_edge = leading ^ q.cfg.cpha;

    always_comb begin
        d = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid && target_ok) begin
                    d.st    = ST_SETUP;
                    d.dev   = req_dev;
                    d.dec   = dec_mode;
                    d.cfg   = sel_cfg;
                    d.cnt   = DIV_W'(sel_cfg.dly);
                    d.sclk  = sel_cfg.cpol;
                    d.tx    = req_data;
                    d.edges = '0;
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_SHIFT;
                    d.cnt = q.cfg.div;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_SHIFT: begin
                if (q.cnt == '0) begin
                    d.cnt   = q.cfg.div;
                    d.sclk  = !q.sclk;
                    d.edges = q.edges + 1'b1;
                    if (sample_edge) d.rx = {q.rx[BYTE_W-2:0], miso};
                    else if (q.edges != '0) d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                    if (q.edges == LAST_EDGE) begin
                        d.st  = ST_HOLD;
                        d.cnt = TAIL_CNT;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (q.cnt == '0) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.rdata = q.rx;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_done  = q.done;
    assign rsp_data  = q.rdata;
    assign sclk      = q.sclk;
    assign mosi      = q.tx[BYTE_W-1];

    a_r11_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (cs_n == '1));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r12_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);
    a_r13_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready) && !rsp_done) |-> $stable(cs_n));
    a_r10_sclk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> (cs_n != '1));
endmodule

// File: tb/spi_csdec_master_tb.sv
module spi_csdec_master_tb;
    localparam int END_DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_dev = '0;
    logic [7:0]  req_data = '0;
    logic        rsp_done;
    logic [7:0]  rsp_data;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;

    spi_csdec_master #(.END_DLY(END_DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_data(req_data), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #4 clk = !clk;

    int checks = 0, failures = 0;
    bit finished = 0;

    // bench shadow of configuration
    int  sh_div [4], sh_dly [4];
    bit  sh_cpol [4], sh_cpha [4];
    bit  sh_dec = 0;

    // monitor state
    int  m_starts = 0, m_dones = 0, m_edges = 0, m_gap = 0, m_setup = 0, m_tail = 0;
    int  m_half_bad = 0, m_cs_bad = 0, m_sclk_bad = 0, m_rdy_bad = 0, sh = 0;
    logic [3:0] m_cs = '1, prev_cs = '1;
    logic prev_sclk = 0;
    bit   mcpol, mcpha, nx_cpol, nx_cpha, edge_seen, lead;
    int   mdiv, nx_div;
    logic [7:0] s_tx, s_rx, nx_stx;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(bit dec, int dev);
        if (dec) return {1'b1, 3'(dev)};
        return ~(4'b1 << dev);
    endfunction

    function automatic int cfg_idx(bit dec, int dev);
        if (dec) return (dev >= 4) ? 1 : 0;
        return dev;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            edge_seen = (sclk !== prev_sclk);
            if (rsp_done) m_dones++;
            if (cs_n != 4'hF && prev_cs == 4'hF) begin
                m_starts++;
                m_cs = cs_n; m_edges = 0; m_gap = 1;
                mcpol = nx_cpol; mcpha = nx_cpha; mdiv = nx_div;
                s_tx = nx_stx; s_rx = '0; sh = 0;
                if (!mcpha) miso = s_tx[7];
            end else if (cs_n != 4'hF) begin
                if (cs_n != m_cs) m_cs_bad++;
                if (req_ready) m_rdy_bad++;
                if (edge_seen) begin
                    if (m_edges == 0) m_setup = m_gap;
                    else if (m_gap != mdiv + 1) m_half_bad++;
                    m_edges++; m_gap = 1;
                    lead = (sclk != mcpol);
                    if (lead ^ mcpha) s_rx = {s_rx[6:0], mosi};
                    else if (mcpha) begin
                        if (sh < 8) miso = s_tx[7-sh];
                        sh++;
                    end else begin
                        sh++;
                        if (sh < 8) miso = s_tx[7-sh];
                    end
                end else m_gap++;
            end else begin
                if (prev_cs != 4'hF) m_tail = m_gap;
                else if (edge_seen) m_sclk_bad++;
            end
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic wr(int addr, logic [15:0] data);
        @(negedge clk);
        reg_we = 1; reg_addr = 3'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic set_cfg(int idx, int div, bit cpol, bit cpha, int dly);
        sh_div[idx] = div; sh_cpol[idx] = cpol; sh_cpha[idx] = cpha; sh_dly[idx] = dly;
        wr(idx, {4'(dly), 2'b00, cpha, cpol, 8'(div)});
    endtask

    task automatic set_mode(bit dec);
        sh_dec = dec;
        wr(4, {15'b0, dec});
    endtask

    task automatic issue(int dev, logic [7:0] data);
        @(negedge clk);
        req_valid = 1; req_dev = 3'(dev); req_data = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic prep(int dev, logic [7:0] stx);
        int ci;
        ci = cfg_idx(sh_dec, dev);
        nx_cpol = sh_cpol[ci]; nx_cpha = sh_cpha[ci]; nx_div = sh_div[ci]; nx_stx = stx;
    endtask

    task automatic wait_done_and_check(int dev, logic [7:0] data, logic [7:0] stx);
        int t = 0, ci, d0;
        string rq;
        ci = cfg_idx(sh_dec, dev);
        rq = sh_dec ? "R4" : "R5";
        d0 = m_dones;
        while (!rsp_done && t < 5000) begin @(negedge clk); t++; end
        chk(t < 5000, "R11", "done seen", t, 0);
        chk(rsp_data == stx, "R10", "received byte", rsp_data, stx);
        chk(cs_n == 4'hF, "R11", "select idle at done", cs_n, 15);
        @(negedge clk);
        chk(!rsp_done, "R11", "done one cycle", rsp_done, 0);
        chk(m_dones == d0 + 1, "R11", "done count", m_dones - d0, 1);
        chk(s_rx == data, "R10", "slave got byte", s_rx, data);
        chk(m_edges == 16, "R10", "edge count", m_edges, 16);
        chk(m_half_bad == 0, "R7", "half-period errors", m_half_bad, 0);
        chk(m_setup == sh_dly[ci] + sh_div[ci] + 2, {rq, "/R8"}, "setup gap", m_setup,
            sh_dly[ci] + sh_div[ci] + 2);
        chk(m_tail == END_DLY, "R9", "tail gap", m_tail, END_DLY);
        chk(m_cs == exp_cs(sh_dec, dev), sh_dec ? "R3" : "R2", "select pattern", m_cs,
            exp_cs(sh_dec, dev));
        chk(m_cs_bad == 0, "R13", "select changes", m_cs_bad, 0);
        chk(m_rdy_bad == 0, "R12", "ready while busy", m_rdy_bad, 0);
        m_half_bad = 0;
    endtask

    task automatic xfer(int dev, logic [7:0] data, logic [7:0] stx);
        prep(dev, stx);
        issue(dev, data);
        wait_done_and_check(dev, data, stx);
    endtask

    task automatic reject(int dev);
        int s0, d0;
        s0 = m_starts; d0 = m_dones;
        issue(dev, 8'hA5);
        repeat (60) @(negedge clk);
        chk(m_starts == s0, "R6", "no select activity", m_starts - s0, 0);
        chk(m_dones == d0, "R6", "no done", m_dones - d0, 0);
        chk(cs_n == 4'hF && req_ready, "R6", "idle after drop", cs_n, 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired R12 actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) begin sh_div[i] = 0; sh_dly[i] = 0; sh_cpol[i] = 0; sh_cpha[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cs_n == 4'hF, "R1", "reset selects", cs_n, 15);
        chk(sclk == 0, "R1", "reset sclk", sclk, 0);
        chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
        chk(rsp_done == 0, "R1", "reset done", rsp_done, 0);

        // direct mode, distinct slots, all four polarity/phase combinations
        set_cfg(0, 0, 0, 0, 0);
        set_cfg(1, 1, 0, 1, 3);
        set_cfg(2, 2, 1, 0, 5);
        set_cfg(3, 3, 1, 1, 1);
        for (int dv = 0; dv < 4; dv++) xfer(dv, 8'h81 + 8'(dv * 17), 8'h3C ^ 8'(dv));
        reject(5);
        reject(4);

        // encoded mode: group boundary 3/4, code 7 dropped
        set_mode(1);
        xfer(3, 8'hC3, 8'h5A);
        xfer(4, 8'h1E, 8'hE1);
        xfer(6, 8'h00, 8'hFF);
        xfer(0, 8'hFF, 8'h00);
        reject(7);

        // slow divider
        set_cfg(1, 255, 0, 1, 15);
        xfer(5, 8'h96, 8'h69);

        // back-to-back requests held across a busy transfer
        begin
            int s0;
            s0 = m_starts;
            prep(2, 8'h11);
            issue(2, 8'h22);
            @(negedge clk);
            req_valid = 1; req_dev = 3'd4; req_data = 8'h44;
            while (!req_ready) @(negedge clk);
            prep(4, 8'h88);
            @(negedge clk);
            req_valid = 0;
            wait_done_and_check(4, 8'h44, 8'h88);
            chk(m_starts == s0 + 2, "R12", "held request served after", m_starts - s0, 2);
        end

        // constrained random
        for (int n = 0; n < 40; n++) begin
            set_mode(1'($urandom_range(1, 0)));
            for (int c = 0; c < 4; c++)
                set_cfg(c, $urandom_range(5, 0), 1'($urandom_range(1, 0)),
                        1'($urandom_range(1, 0)), $urandom_range(15, 0));
            begin
                int dv;
                dv = sh_dec ? $urandom_range(6, 0) : $urandom_range(3, 0);
                xfer(dv, 8'($urandom), 8'($urandom));
            end
        end

        chk(m_sclk_bad == 0, "R10", "sclk moved while idle", m_sclk_bad, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule